// File: doc/BRIEF.md
# Busy Ratio Normalizer

This block turns one measurement window of activity counts into a utilization figure on a fixed scale of 0 to 1000. It then applies that figure to an elapsed-time value measured separately, which gives the busy time for the same window. A frequency-scaling controller uses it once per sampling window: the controller presents the busy-cycle count, the total-cycle count, an overflow flag and the elapsed time, pulses start, and waits for done.

The ratio is pinned at full scale when the counts cannot be trusted. This happens when the counter overflow flag is set, when the total count is zero, or when the busy count is larger than the total. In every other case the ratio is the floored quotient of busy times 1000 over total. A single restoring shift-subtract divider is shared by both divisions, which run one after the other. The two outputs are registered, change only in the cycle in which done is high, and hold their values in between.

Top module: `busy_ratio_norm`

## Requirements
- R1: During and just after reset, `active_o` and `done_o` are 0 and `ratio_o` and `busy_time_o` are 0.
- R2: When `ovf_i` is 1 at the start, `ratio_o` is 1000, whatever the two counts are.
- R3: When `ovf_i` is 0 and `total_cnt_i` is 0 at the start, `ratio_o` is 1000.
- R4: When `ovf_i` is 0 and `busy_cnt_i` is greater than `total_cnt_i` at the start, `ratio_o` is 1000.
- R5: In all other cases, `ratio_o` is floor(`busy_cnt_i` × 1000 / `total_cnt_i`). It never exceeds 1000.
- R6: `busy_time_o` is floor(`elapsed_i` × ratio / 1000), using the ratio from the same operation.
- R7: A start is accepted only while `active_o` is 0. `active_o` goes to 1 on the clock edge that accepts a start and returns to 0 on the edge that raises `done_o`. A start seen while `active_o` is 1 changes neither the result nor the timing.
- R8: `done_o` is a pulse one cycle long. It rises 2·W+4 clock edges after the accepting edge when a division by the total is needed, and W+2 edges after it when the ratio is forced to 1000. W is `ELAPSED_W`+10, which gives 104 and 52 edges at the defaults.
- R9: `ratio_o` and `busy_time_o` change only in a cycle in which `done_o` is 1. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts an operation. Accepted only while idle |
| busy_cnt_i | input | CNT_W (31) | Busy cycles counted in the window |
| total_cnt_i | input | CNT_W (31) | Total cycles counted in the window |
| ovf_i | input | 1 | The total counter overflowed in the window |
| elapsed_i | input | ELAPSED_W (40) | Elapsed time of the window |
| active_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the outputs update |
| ratio_o | output | 10 | Utilization, from 0 to 1000 |
| busy_time_o | output | ELAPSED_W (40) | Elapsed time scaled by the ratio |

## Verification
The divide path is tried with plain ratios (half load, a third with a non-zero remainder, zero busy). It is also tried with busy equal to total at the widest count, and with busy one below total combined with the largest elapsed value. Together these separate the floor rounding, the carry at full scale and the precision of the wide intermediate. Overflow, a zero total and busy above total each go through the forced path. This shows that the three conditions are decoded separately and that the forced path uses the shorter latency. Stray starts during an operation, and a start issued in the same cycle as done, show whether requests are correctly ignored while active and whether back-to-back operations work.

// File: rtl/busy_ratio_pkg.sv
package busy_ratio_pkg;
  localparam int unsigned FULL_SCALE = 1000;
  localparam int unsigned RATIO_W    = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RATIO = 2'd1,
    ST_SCALE = 2'd2
  } brn_state_e;
endpackage

// File: rtl/brn_classify.sv
// Decides whether the counts can be divided or whether the ratio must be pinned at full scale.
module brn_classify #(
  parameter int CNT_W = 31
) (
  input  logic [CNT_W-1:0] busy_cnt_i,
  input  logic [CNT_W-1:0] total_cnt_i,
  input  logic             ovf_i,
  output logic             force_full_o
);
  logic total_zero;
  logic busy_above;

  assign total_zero   = (total_cnt_i == '0);
  assign busy_above   = (busy_cnt_i > total_cnt_i);
  assign force_full_o = ovf_i | total_zero | busy_above;
endmodule

// File: rtl/brn_restoring_div.sv
// Restoring shift-subtract divider. Each cycle produces one quotient bit, MSB first.
module brn_restoring_div #(
  parameter int NUM_W = 50,
  parameter int DEN_W = 31,
  parameter int Q_W   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             valid_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q;
  logic             valid_q;

  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  assign trial = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        den_q <= den_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff : trial;
        quo_q <= {quo_q[NUM_W-2:0], fits};
        if (cnt_q == CW'(NUM_W - 1)) begin
          run_q   <= 1'b0;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign quo_o   = quo_q[Q_W-1:0];
endmodule

// File: rtl/busy_ratio_norm.sv
module busy_ratio_norm
  import busy_ratio_pkg::*;
#(
  parameter int CNT_W     = 31,
  parameter int ELAPSED_W = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     busy_cnt_i,
  input  logic [CNT_W-1:0]     total_cnt_i,
  input  logic                 ovf_i,
  input  logic [ELAPSED_W-1:0] elapsed_i,
  output logic                 active_o,
  output logic                 done_o,
  output logic [9:0]           ratio_o,
  output logic [ELAPSED_W-1:0] busy_time_o
);
  // The dividend must hold busy*1000 and elapsed*1000. CNT_W must be at least RATIO_W.
  localparam int WIDE_W = (CNT_W > ELAPSED_W) ? CNT_W : ELAPSED_W;
  localparam int NUM_W  = WIDE_W + RATIO_W;
  localparam int DEN_W  = CNT_W;

  brn_state_e           state_q;
  logic [ELAPSED_W-1:0] elapsed_q;
  logic [RATIO_W-1:0]   ratio_int_q;
  logic [RATIO_W-1:0]   ratio_q;
  logic [ELAPSED_W-1:0] btime_q;
  logic [NUM_W-1:0]     num_q;
  logic [DEN_W-1:0]     den_q;
  logic                 go_q;
  logic                 done_q;
  logic                 active_q;

  logic                 force_full;
  logic                 div_valid;
  logic [ELAPSED_W-1:0] div_quo;

  brn_classify #(.CNT_W(CNT_W)) u_classify (
    .busy_cnt_i   (busy_cnt_i),
    .total_cnt_i  (total_cnt_i),
    .ovf_i        (ovf_i),
    .force_full_o (force_full)
  );

  brn_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(ELAPSED_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .go_i    (go_q),
    .num_i   (num_q),
    .den_i   (den_q),
    .valid_o (div_valid),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      elapsed_q   <= '0;
      ratio_int_q <= '0;
      ratio_q     <= '0;
      btime_q     <= '0;
      num_q       <= '0;
      den_q       <= '0;
      go_q        <= 1'b0;
      done_q      <= 1'b0;
      active_q    <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            elapsed_q <= elapsed_i;
            active_q  <= 1'b1;
            go_q      <= 1'b1;
            if (force_full) begin
              // The counts are not trusted, so the only division left is the scaling by full scale.
              ratio_int_q <= RATIO_W'(FULL_SCALE);
              num_q       <= NUM_W'(elapsed_i) * NUM_W'(FULL_SCALE);
              den_q       <= DEN_W'(FULL_SCALE);
              state_q     <= ST_SCALE;
            end else begin
              num_q   <= NUM_W'(busy_cnt_i) * NUM_W'(FULL_SCALE);
              den_q   <= total_cnt_i;
              state_q <= ST_RATIO;
            end
          end
        end
        ST_RATIO: begin
          if (div_valid) begin
            ratio_int_q <= div_quo[RATIO_W-1:0];
            num_q       <= NUM_W'(elapsed_q) * NUM_W'(div_quo[RATIO_W-1:0]);
            den_q       <= DEN_W'(FULL_SCALE);
            go_q        <= 1'b1;
            state_q     <= ST_SCALE;
          end
        end
        ST_SCALE: begin
          if (div_valid) begin
            ratio_q  <= ratio_int_q;
            btime_q  <= div_quo;
            done_q   <= 1'b1;
            active_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o    = active_q;
  assign done_o      = done_q;
  assign ratio_o     = ratio_q;
  assign busy_time_o = btime_q;
endmodule

// File: rtl/brn_checker.sv
module brn_checker #(
  parameter int ELAPSED_W = 40
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start_i,
  input logic                 active_o,
  input logic                 done_o,
  input logic [9:0]           ratio_o,
  input logic [ELAPSED_W-1:0] busy_time_o
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_ratio_cap_r5: assert property (@(posedge clk) disable iff (rst)
    ratio_o <= 10'd1000);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(ratio_o) && $stable(busy_time_o)));

  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(start_i));

  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !active_o);

  p_done_follows_work_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(active_o));
endmodule

bind busy_ratio_norm brn_checker #(.ELAPSED_W(ELAPSED_W)) u_brn_checker (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .active_o    (active_o),
  .done_o      (done_o),
  .ratio_o     (ratio_o),
  .busy_time_o (busy_time_o)
);

// File: tb/busy_ratio_norm_bench.sv
module busy_ratio_norm_bench;
  localparam int CNT_W     = 31;
  localparam int ELAPSED_W = 40;
  localparam int NW        = ELAPSED_W + 10;
  localparam int LAT_CALC  = 2 * NW + 4;
  localparam int LAT_FORCE = NW + 2;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start_i = 1'b0;
  logic [CNT_W-1:0]     busy_cnt_i = '0;
  logic [CNT_W-1:0]     total_cnt_i = '0;
  logic                 ovf_i = 1'b0;
  logic [ELAPSED_W-1:0] elapsed_i = '0;
  logic                 active_o;
  logic                 done_o;
  logic [9:0]           ratio_o;
  logic [ELAPSED_W-1:0] busy_time_o;

  always #4 clk = ~clk;

  busy_ratio_norm #(.CNT_W(CNT_W), .ELAPSED_W(ELAPSED_W)) u_busy_ratio_norm (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_cnt_i(busy_cnt_i),
    .total_cnt_i(total_cnt_i), .ovf_i(ovf_i), .elapsed_i(elapsed_i),
    .active_o(active_o), .done_o(done_o), .ratio_o(ratio_o), .busy_time_o(busy_time_o)
  );

  int vecs = 0;
  int errs = 0;

  // Behavioural model state
  bit              m_act = 0;
  int              m_cnt = 0;
  longint unsigned m_pr = 0, m_pb = 0;
  longint unsigned e_ratio = 0, e_bt = 0;
  bit              e_done = 0;

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Advances the model by one clock edge, using the inputs as they will be sampled at that edge.
  task automatic model_edge();
    longint unsigned b, t, r;
    e_done = 0;
    if (m_act) begin
      m_cnt--;
      if (m_cnt == 0) begin
        e_done  = 1;
        e_ratio = m_pr;
        e_bt    = m_pb;
        m_act   = 0;
      end
    end else if (start_i) begin
      b = longint'(busy_cnt_i);
      t = longint'(total_cnt_i);
      if (ovf_i || t == 0 || b > t) begin
        r = 1000; m_cnt = LAT_FORCE;
      end else begin
        r = (b * 1000) / t; m_cnt = LAT_CALC;
      end
      m_pr  = r;
      m_pb  = (longint'(elapsed_i) * r) / 1000;
      m_act = 1;
    end
  endtask

  task automatic step(bit s, longint unsigned b, longint unsigned t, bit o, longint unsigned e, string rtag);
    start_i     = s;
    busy_cnt_i  = CNT_W'(b);
    total_cnt_i = CNT_W'(t);
    ovf_i       = o;
    elapsed_i   = ELAPSED_W'(e);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(e_done ? rtag : "R9", "ratio", longint'(ratio_o), e_ratio);
    chk(e_done ? "R6" : "R9", "busy_time", longint'(busy_time_o), e_bt);
    chk("R8", "done", longint'(done_o), longint'(e_done));
    chk("R7", "active", longint'(active_o), longint'(m_act));
  endtask

  // poke > 0 sends stray starts with other data at that step and the next one.
  task automatic run_op(longint unsigned b, longint unsigned t, bit o, longint unsigned e,
                        string rtag, int poke, int tail);
    int n = 0;
    step(1, b, t, o, e, rtag);
    while (m_act) begin
      n++;
      if (n == poke || n == poke + 1) step(1, 1, 1, 0, 7, rtag);
      else step(0, 0, 0, 0, 0, rtag);
    end
    for (int i = 0; i < tail; i++) step(0, 0, 0, 0, 0, rtag);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1", "active", longint'(active_o), 0);
    chk("R1", "done", longint'(done_o), 0);
    chk("R1", "ratio", longint'(ratio_o), 0);
    chk("R1", "busy_time", longint'(busy_time_o), 0);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, "R1");
    chk("R1", "ratio after release", longint'(ratio_o), 0);

    run_op(500, 1000, 0, 1000000, "R5", 0, 2);
    run_op(1, 3, 0, 999, "R5", 0, 2);
    run_op(0, 12345, 0, 77, "R5", 0, 2);
    run_op(64'h7FFF_FFFF, 64'h7FFF_FFFF, 0, 123456789, "R5", 0, 2);
    run_op(64'h7FFF_FFFE, 64'h7FFF_FFFF, 0, 64'hFF_FFFF_FFFF, "R5", 0, 2);
    run_op(0, 100, 1, 5000, "R2", 10, 2);
    run_op(40, 0, 0, 3333, "R3", 0, 2);
    run_op(101, 100, 0, 9999, "R4", 0, 0);
    run_op(7, 9, 0, 86421, "R5", 30, 0);
    run_op(250, 1000, 0, 4, "R6", 60, 3);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule